// File: doc/BRIEF.md
# Memory-Mapped UART Register Front End

This block sits between a simple synchronous register bus and the bit-level serial engine of a small UART. It decodes eight byte-wide registers, one per 32-bit word. Four of them are identification bytes. The others are a data port, a combined status/control byte, and the two halves of the baud divisor. Received bytes arrive from the serial engine on a one-cycle strobe and queue in a four-entry receive FIFO. Software drains the FIFO by reading the data port repeatedly until the status byte reports it empty. A transmit byte written to the data port is held in a single-entry holding register until the serial engine accepts it.

The transmit side is a two-state machine. In `TX_IDLE` the holding register is free and status bit 7 reads 1. The LOAD transition (a data-port write in `TX_IDLE`) stores the byte and moves to `TX_LOADED`. In that state `tx_req` offers the byte and further data-port writes are dropped. The RELEASE transition (`tx_ack` in `TX_LOADED`) returns to `TX_IDLE`.

Frame and overflow errors are kept as sticky status bits. Software clears them with a read-modify-write of the status byte. One interrupt line combines the receive and transmit causes.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status byte reads 0xA0 (FIFO empty bit 5 and transmit-empty bit 7 set, all else 0), `irq` and `tx_req` are 0, and the divisor reads the `DIV_RST` parameter.
- R2: Word indices 0..3 (byte offsets 0, 4, 8, 12) read the parameter bytes `ID_B0`..`ID_B3`. Writes to them have no effect.
- R3: The receive FIFO holds four bytes and returns them in arrival order. Each read of word index 4 (offset 16) pops one byte. A read while the FIFO is empty returns 0x00 and changes nothing.
- R4: Status bit 3 is 1 exactly when four bytes are held. Bit 4 is 1 exactly when three are held. Bit 5 is 1 exactly when none are held.
- R5: A byte strobed in while four bytes are held is discarded, the stored bytes are kept, and overflow bit 1 sets.
- R6: A byte strobed in with `rx_ferr` high is stored normally and sets frame-error bit 0.
- R7: A write to word index 5 (offset 20) clears bit 0 or bit 1 when that bit is written 0 and leaves it unchanged when it is written 1. A new error in the same cycle keeps the bit set. Bits 2 (receive enable) and 6 (transmit enable) take the written value. Bits 3, 4, 5 and 7 ignore writes.
- R8: A data-port write while bit 7 is 1 loads the byte, clears bit 7, and raises `tx_req` with the byte on `tx_byte`. The byte is held until a cycle with `tx_ack`, after which bit 7 returns to 1. A data-port write while bit 7 is 0 is dropped.
- R9: `irq` is 1 when (bit 2 and (FIFO non-empty or bit 0 or bit 1)) or (bit 6 and bit 7), one cycle after the event that changes those bits.
- R10: Word indices 6 and 7 (offsets 24, 28) are the low and high divisor bytes. They are readable and writable and drive `baud_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received-byte strobe from serial engine |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Stop bit missing on this byte |
| tx_req | output | 1 | Holding register has a byte to send |
| tx_byte | output | 8 | Byte offered to serial engine |
| tx_ack | input | 1 | Serial engine takes the offered byte |
| baud_div | output | 16 | Baud divisor to serial engine |
| irq | output | 1 | Combined receive/transmit interrupt |

## Verification
The receive FIFO is exercised with three fills that separate its levels: three bytes (one slot left), four bytes (full), and a fifth byte (overflow with discard). Each fill is followed by a drain whose order is compared against a queue of expected bytes. Frame-error bytes are sent alone and together with a status write in the same cycle, which shows whether set or clear wins. The transmit holding register is loaded while the simulated engine withholds `tx_ack`, and a second write is attempted then; a byte that gets overwritten or sent twice shows up against the transmit queue. The interrupt is observed across enable changes, FIFO drains, and error clears, so each cause is seen asserting and deasserting it independently.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

    localparam int DW = 8;
    localparam int WA_W = 3;

    typedef enum logic [WA_W-1:0] {
        REG_ID0  = 3'd0,
        REG_ID1  = 3'd1,
        REG_ID2  = 3'd2,
        REG_ID3  = 3'd3,
        REG_DATA = 3'd4,
        REG_STAT = 3'd5,
        REG_DIVL = 3'd6,
        REG_DIVH = 3'd7
    } reg_idx_e;

    localparam int ST_FERR  = 0;
    localparam int ST_OVF   = 1;
    localparam int ST_RXIE  = 2;
    localparam int ST_FULL  = 3;
    localparam int ST_ONE   = 4;
    localparam int ST_EMPTY = 5;
    localparam int ST_TXIE  = 6;
    localparam int ST_TXMT  = 7;

    typedef enum logic {
        TX_IDLE   = 1'b0,
        TX_LOADED = 1'b1
    } tx_state_e;

endpackage

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic          lvl_empty,
    output logic          lvl_full,
    output logic          lvl_one_left,
    output logic          drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          push_fire, pop_fire;
    logic [DW-1:0] slot_vec [DEPTH];

    assign push_fire = push_req && (count_q != CW'(DEPTH));
    assign pop_fire  = pop_req && (count_q != '0);
    assign drop      = push_req && (count_q == CW'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (push_fire && (wr_ptr_q == PW'(i))) begin
                slot_q <= push_data;
            end
        end
        assign slot_vec[i] = slot_q;
    end

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_fire) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop_fire)  rd_ptr_q <= ptr_next(rd_ptr_q);
            unique case ({push_fire, pop_fire})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign lvl_empty    = (count_q == '0);
    assign lvl_full     = (count_q == CW'(DEPTH));
    assign lvl_one_left = (count_q == CW'(DEPTH - 1));
    assign head         = lvl_empty ? '0 : slot_vec[rd_ptr_q];

    // R5: a dropped byte leaves the level at full
    a_r5_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop_req) |=> lvl_full);

    // R3: a pop without a push lowers the level by one
    a_r3_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !push_fire) |=> (count_q == $past(count_q) - CW'(1)));

    // R3: read pointer never moves while empty
    a_r3_empty_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_empty && !push_req) |=> $stable(rd_ptr_q));

endmodule

// File: rtl/urf_tx_hold.sv
module urf_tx_hold
    import uart_regfront_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_req,
    input  logic [W-1:0] load_byte,
    input  logic         tx_ack,
    output logic         tx_req,
    output logic [W-1:0] tx_byte,
    output logic         tx_empty
);
    tx_state_e    state_q, state_d;
    logic         load_fire;
    logic [W-1:0] byte_q;

    always_comb begin
        state_d   = state_q;
        load_fire = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (load_req) begin
                    state_d   = TX_LOADED;
                    load_fire = 1'b1;
                end
            end
            TX_LOADED: begin
                if (tx_ack) state_d = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         byte_q <= '0;
        else if (load_fire) byte_q <= load_byte;
    end

    always_comb begin
        tx_req   = 1'b0;
        tx_empty = 1'b0;
        unique case (state_q)
            TX_IDLE:   tx_empty = 1'b1;
            TX_LOADED: tx_req   = 1'b1;
        endcase
        tx_byte = byte_q;
    end

    // R8: the offered byte is held until the engine takes it
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack) |=> (tx_req && $stable(tx_byte)));

    // R8: acceptance frees the holding register
    a_r8_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_ack) |=> tx_empty);

endmodule

// File: rtl/urf_status.sv
module urf_status
    import uart_regfront_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_ferr_keep,
    input  logic          wr_ovf_keep,
    input  logic          wr_rxie,
    input  logic          wr_txie,
    input  logic          ferr_evt,
    input  logic          ovf_evt,
    input  logic          fifo_empty,
    input  logic          fifo_full,
    input  logic          fifo_one_left,
    input  logic          tx_empty,
    output logic [DW-1:0] status_byte,
    output logic          irq
);
    logic ferr_q, ovf_q, rxie_q, txie_q;
    logic rx_cause, tx_cause;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr_q <= 1'b0;
            ovf_q  <= 1'b0;
            rxie_q <= 1'b0;
            txie_q <= 1'b0;
        end else begin
            ferr_q <= ferr_evt | (ferr_q & (~wr_en | wr_ferr_keep));
            ovf_q  <= ovf_evt  | (ovf_q  & (~wr_en | wr_ovf_keep));
            if (wr_en) begin
                rxie_q <= wr_rxie;
                txie_q <= wr_txie;
            end
        end
    end

    always_comb begin
        status_byte           = '0;
        status_byte[ST_FERR]  = ferr_q;
        status_byte[ST_OVF]   = ovf_q;
        status_byte[ST_RXIE]  = rxie_q;
        status_byte[ST_FULL]  = fifo_full;
        status_byte[ST_ONE]   = fifo_one_left;
        status_byte[ST_EMPTY] = fifo_empty;
        status_byte[ST_TXIE]  = txie_q;
        status_byte[ST_TXMT]  = tx_empty;
    end

    assign rx_cause = rxie_q & (~fifo_empty | ferr_q | ovf_q);
    assign tx_cause = txie_q & tx_empty;
    assign irq      = rx_cause | tx_cause;

    // R6: a frame error is visible on the next cycle
    a_r6_ferr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_evt |=> status_byte[ST_FERR]);

    // R5: an overflow is visible on the next cycle
    a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> status_byte[ST_OVF]);

    // R7: without an error event or a status write, the error bits hold
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ferr_evt && !ovf_evt) |=> $stable(status_byte[ST_OVF:ST_FERR]));

    // R9: with both enables off no interrupt is raised
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_byte[ST_RXIE] && !status_byte[ST_TXIE]) |-> !irq);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int          RX_DEPTH = 4,
    parameter logic [7:0]  ID_B0    = 8'h3C,
    parameter logic [7:0]  ID_B1    = 8'hA5,
    parameter logic [7:0]  ID_B2    = 8'h01,
    parameter logic [7:0]  ID_B3    = 8'h7E,
    parameter logic [15:0] DIV_RST  = 16'h0019
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [WA_W-1:0] bus_waddr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            rx_valid,
    input  logic [DW-1:0]   rx_byte,
    input  logic            rx_ferr,
    output logic            tx_req,
    output logic [DW-1:0]   tx_byte,
    input  logic            tx_ack,
    output logic [2*DW-1:0] baud_div,
    output logic            irq
);
    reg_idx_e      idx;
    logic          rd_en, wr_en;
    logic          data_rd, data_wr, stat_wr;
    logic [DW-1:0] rx_head, status_byte, rd_mux;
    logic          f_empty, f_full, f_one, f_drop;
    logic          tx_mt;
    logic [DW-1:0] div_lo_q, div_hi_q;

    assign idx     = reg_idx_e'(bus_waddr);
    assign rd_en   = bus_sel & ~bus_wr;
    assign wr_en   = bus_sel & bus_wr;
    assign data_rd = rd_en & (idx == REG_DATA);
    assign data_wr = wr_en & (idx == REG_DATA);
    assign stat_wr = wr_en & (idx == REG_STAT);

    urf_rx_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_req     (rx_valid),
        .push_data    (rx_byte),
        .pop_req      (data_rd),
        .head         (rx_head),
        .lvl_empty    (f_empty),
        .lvl_full     (f_full),
        .lvl_one_left (f_one),
        .drop         (f_drop)
    );

    urf_tx_hold #(.W(DW)) u_txh (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (data_wr),
        .load_byte (bus_wdata),
        .tx_ack    (tx_ack),
        .tx_req    (tx_req),
        .tx_byte   (tx_byte),
        .tx_empty  (tx_mt)
    );

    urf_status u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (stat_wr),
        .wr_ferr_keep  (bus_wdata[ST_FERR]),
        .wr_ovf_keep   (bus_wdata[ST_OVF]),
        .wr_rxie       (bus_wdata[ST_RXIE]),
        .wr_txie       (bus_wdata[ST_TXIE]),
        .ferr_evt      (rx_valid & rx_ferr),
        .ovf_evt       (f_drop),
        .fifo_empty    (f_empty),
        .fifo_full     (f_full),
        .fifo_one_left (f_one),
        .tx_empty      (tx_mt),
        .status_byte   (status_byte),
        .irq           (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo_q <= DIV_RST[DW-1:0];
            div_hi_q <= DIV_RST[2*DW-1:DW];
        end else if (wr_en) begin
            if (idx == REG_DIVL) div_lo_q <= bus_wdata;
            if (idx == REG_DIVH) div_hi_q <= bus_wdata;
        end
    end

    assign baud_div = {div_hi_q, div_lo_q};

    always_comb begin
        unique case (idx)
            REG_ID0:  rd_mux = ID_B0;
            REG_ID1:  rd_mux = ID_B1;
            REG_ID2:  rd_mux = ID_B2;
            REG_ID3:  rd_mux = ID_B3;
            REG_DATA: rd_mux = rx_head;
            REG_STAT: rd_mux = status_byte;
            REG_DIVL: rd_mux = div_lo_q;
            REG_DIVH: rd_mux = div_hi_q;
        endcase
        bus_rdata = rd_en ? rd_mux : '0;
    end

    // R10: the divisor only moves on a write to its own registers
    a_r10_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (idx == REG_DIVL || idx == REG_DIVH)) |=> $stable(baud_div));

    // R8: a data-port write while loaded does not change the offered byte
    a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_req && !tx_ack) |=> $stable(tx_byte));

endmodule

// File: tb/uart_regfront_bench.sv
`timescale 1ns/1ps
module uart_regfront_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rx_valid = 1'b0, rx_ferr = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_req, tx_ack = 1'b0;
    logic [7:0]  tx_byte;
    logic [15:0] baud_div;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit tx_auto = 1'b0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];

    always #2 clk = ~clk;

    uart_regfront u_uart_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ferr(rx_ferr),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack),
        .baud_div(baud_div), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic fe, input bit stored);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_ferr = fe;
        if (stored) exp_rx.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0; rx_ferr = 1'b0;
    endtask

    // scoreboard consumer for the receive path
    task automatic rd_data_chk(input string req);
        logic [7:0] d;
        logic [7:0] e;
        rd_reg(3'd4, d);
        e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 8'h00;
        chk(req, {8'h00, d}, {8'h00, e});
    endtask

    task automatic stat_chk(input string req, input logic [7:0] e);
        logic [7:0] d;
        rd_reg(3'd5, d);
        chk(req, {8'h00, d}, {8'h00, e});
    endtask

    // model of the serial engine: takes each offered byte and compares it
    initial begin
        forever begin
            @(negedge clk);
            if (tx_auto && tx_req && !tx_ack) begin
                checks++;
                if (exp_tx.size() == 0) begin
                    errors++;
                    $display("FAIL R8 actual=%h expected=<none>", tx_byte);
                end else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    if (tx_byte !== e) begin
                        errors++;
                        $display("FAIL R8 actual=%h expected=%h", tx_byte, e);
                    end
                end
                tx_ack = 1'b1;
            end else begin
                tx_ack = 1'b0;
            end
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        stat_chk("R1 status", 8'hA0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 tx_req", {15'd0, tx_req}, 16'd0);
        chk("R1 baud_div", baud_div, 16'h0019);
        rd_reg(3'd6, d); chk("R1 divl", {8'h0, d}, 16'h0019);
        rd_reg(3'd7, d); chk("R1 divh", {8'h0, d}, 16'h0000);

        // R2 identification bytes
        rd_reg(3'd0, d); chk("R2 id0", {8'h0, d}, 16'h003C);
        rd_reg(3'd2, d); chk("R2 id2", {8'h0, d}, 16'h0001);
        rd_reg(3'd3, d); chk("R2 id3", {8'h0, d}, 16'h007E);
        wr_reg(3'd1, 8'hFF);
        rd_reg(3'd1, d); chk("R2 id1 after write", {8'h0, d}, 16'h00A5);

        // R3 read on empty FIFO
        rd_data_chk("R3 empty read");
        stat_chk("R3 status unchanged", 8'hA0);

        // R4 levels, R5 overflow, R3 order
        rx_send(8'h11, 1'b0, 1'b1);
        rx_send(8'h22, 1'b0, 1'b1);
        rx_send(8'h33, 1'b0, 1'b1);
        stat_chk("R4 one slot left", 8'h90);
        rx_send(8'h44, 1'b0, 1'b1);
        stat_chk("R4 full", 8'h88);
        rx_send(8'h55, 1'b0, 1'b0);
        stat_chk("R5 overflow flag", 8'h8A);
        for (int i = 0; i < 4; i++) rd_data_chk("R3 R5 drain order");
        stat_chk("R4 empty after drain", 8'hA2);
        rd_data_chk("R3 read past empty");

        // R7 sticky clear semantics and read-only bits
        wr_reg(3'd5, 8'h02);
        stat_chk("R7 write one keeps", 8'hA2);
        wr_reg(3'd5, 8'hBA);
        stat_chk("R7 read-only bits", 8'hA2);
        wr_reg(3'd5, 8'h00);
        stat_chk("R7 write zero clears", 8'hA0);

        // R6 frame error
        rx_send(8'h66, 1'b1, 1'b1);
        stat_chk("R6 ferr set and byte held", 8'h81);
        rd_data_chk("R6 byte stored");
        stat_chk("R6 ferr sticky", 8'hA1);
        wr_reg(3'd5, 8'h00);
        stat_chk("R6 ferr cleared", 8'hA0);

        // R7 new error wins over a same-cycle clear
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h77; rx_ferr = 1'b1; exp_rx.push_back(8'h77);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = 3'd5; bus_wdata = 8'h00;
        @(negedge clk);
        rx_valid = 1'b0; rx_ferr = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        stat_chk("R7 set wins", 8'h81);
        rd_data_chk("R7 byte kept");
        wr_reg(3'd5, 8'h00);

        // R9 receive interrupt
        wr_reg(3'd5, 8'h04);
        chk("R9 idle with rxie", {15'd0, irq}, 16'd0);
        rx_send(8'h12, 1'b0, 1'b1);
        chk("R9 data pending", {15'd0, irq}, 16'd1);
        rd_data_chk("R9 pop");
        chk("R9 drained", {15'd0, irq}, 16'd0);
        rx_send(8'h34, 1'b1, 1'b1);
        rd_data_chk("R9 pop err byte");
        chk("R9 error keeps irq", {15'd0, irq}, 16'd1);
        wr_reg(3'd5, 8'h04);
        chk("R9 error cleared", {15'd0, irq}, 16'd0);
        wr_reg(3'd5, 8'h40);
        chk("R9 tx room irq", {15'd0, irq}, 16'd1);

        // R8 holding register
        exp_tx.push_back(8'h5A);
        wr_reg(3'd4, 8'h5A);
        chk("R8 tx_req", {15'd0, tx_req}, 16'd1);
        chk("R8 tx_byte", {8'h0, tx_byte}, 16'h005A);
        stat_chk("R8 tx busy status", 8'h60);
        chk("R9 tx busy no irq", {15'd0, irq}, 16'd0);
        wr_reg(3'd4, 8'h33);
        chk("R8 busy write dropped", {8'h0, tx_byte}, 16'h005A);
        tx_auto = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 released", {15'd0, tx_req}, 16'd0);
        stat_chk("R8 empty again", 8'hE0);
        exp_tx.push_back(8'hC3);
        wr_reg(3'd4, 8'hC3);
        repeat (4) @(negedge clk);
        chk("R8 all sent", exp_tx.size(), 16'd0);

        // R10 divisor
        wr_reg(3'd6, 8'h34);
        wr_reg(3'd7, 8'h12);
        chk("R10 baud_div", baud_div, 16'h1234);
        rd_reg(3'd6, d); chk("R10 divl", {8'h0, d}, 16'h0034);
        rd_reg(3'd7, d); chk("R10 divh", {8'h0, d}, 16'h0012);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule